// File: doc/BRIEF.md
# Crossbar Synapse Pulse Sequencer

This block produces the digital control waveforms that drive a square resistive synapse crossbar. Each neuron owns one wordline, which gates the selection transistors of its row, and one bitline, which reaches the top electrodes of its column. The sequencer has two commands.

An initialisation command applies a RESET-shaped pulse to every cell. It works one row at a time, starting with row 0 and ending with the last row. A learning epoch command samples a firing vector and then drives every neuron for one epoch window:
- A firing neuron gates its wordline and sends a programming (SET-shaped) pulse on its bitline.
- A silent neuron sends only a read pulse on its bitline and leaves its wordline off.

Strengthening is gradual. The controller issues further epochs with the same firing pattern, and every epoch delivers a fresh programming pulse.

Every pulse has three timed phases: rise, flat top and fall. The block reports the current phase on each bitline as a strobe code, so an external converter can ramp its output. It reports the amplitude class as a 2-bit mode code. Phase lengths are set in nanoseconds and converted to whole clock cycles. A one-cycle `done` pulse marks the end of each command.

Top module: `xps_pulse_seq`

## Requirements
- R1: After a synchronous reset, all outputs are low: `wl_gate`, `bl_mode`, `bl_phase`, `busy` and `done`.
- R2: A phase of d ns lasts max(1, ceil(d*1000/CLK_PS)) cycles. The phase code is 01 for rise, 10 for flat, 11 for fall and 00 when no pulse is active.
- R3: Initialisation visits the rows in ascending order, with one slot of (reset rise + flat + fall) cycles per row. During its slot, a row's wordline is high for the whole pulse, and only that wordline is high.
- R4: An epoch command is ignored until one initialisation has completed since reset.
- R5: In an epoch, a firing neuron's wordline is high for the whole SET-shaped pulse, and its bitline carries mode 10 with the SET phases.
- R6: In an epoch, a silent neuron's wordline stays low, and its bitline carries mode 01 with the read-pulse phases.
- R7: A row whose row enable was low at the command never gates its wordline. A column whose column enable was low keeps mode 00 and phase 00.
- R8: The firing vector and both enable vectors are sampled only at the command edge. Later changes have no effect until the next command.
- R9: Let the command be sampled at edge 0. Pulse cycle k appears on the outputs after edge k+1. `done` is high for exactly one cycle after edge L, where L is the epoch length in cycles or N times the reset slot. `busy` is high after edges 0 to L-1.
- R10: Commands that arrive while busy are ignored. When both commands arrive in the same idle cycle, initialisation wins.
- R11: Consecutive epochs each deliver a complete new programming pulse to the firing neurons.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| epoch_start | input | 1 | Start a learning epoch (one-cycle pulse) |
| init_start | input | 1 | Start row-by-row RESET of all cells |
| fire_vec | input | N | Firing state per neuron |
| row_en | input | N | Per-row wordline enable |
| col_en | input | N | Per-column bitline enable |
| wl_gate | output | N | Wordline gate per row |
| bl_mode | output | 2*N | Mode per bitline: 00 idle, 01 read, 10 set/program, 11 reset |
| bl_phase | output | 2*N | Phase strobe per bitline: 00 none, 01 rise, 10 flat, 11 fall |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse when the command window closes |

## Verification
Let the command be sampled at edge 0. The drive for pulse cycle k is due on the ports after edge k+1. `done` is due after edge L, and `busy` falls on that same edge.

The bench's behavioural model follows these rules, counting edges from the command. It computes the expected value of every output at each rising edge and compares them at the following falling edge, so each comparison sees exactly the cycle the requirements assign.

Separate counters measure how long each phase lasts. They also confirm that disabled lines and lines changed mid-epoch never move.

// File: rtl/xps_pkg.sv
package xps_pkg;

  typedef enum logic [1:0] {
    MD_IDLE  = 2'b00,
    MD_READ  = 2'b01,
    MD_SET   = 2'b10,
    MD_RESET = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    PH_NONE = 2'b00,
    PH_RISE = 2'b01,
    PH_FLAT = 2'b10,
    PH_FALL = 2'b11
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_EPOCH = 2'b01,
    ST_INIT  = 2'b10
  } st_e;

  // nanoseconds to whole cycles, rounded up, never below one cycle
  function automatic int ns2cyc(input int ns, input int clk_ps);
    int c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/xps_phase_timer.sv
module xps_phase_timer
  import xps_pkg::*;
#(
  parameter int TW   = 16,
  parameter int RISE = 1,
  parameter int FLAT = 1,
  parameter int FALL = 1
) (
  input  logic [TW-1:0] t,
  output phase_e        ph
);
  localparam int B1 = RISE;
  localparam int B2 = RISE + FLAT;
  localparam int B3 = RISE + FLAT + FALL;
  localparam logic [TW-1:0] E1 = TW'(B1);
  localparam logic [TW-1:0] E2 = TW'(B2);
  localparam logic [TW-1:0] E3 = TW'(B3);

  always_comb begin
    if (t < E1)      ph = PH_RISE;
    else if (t < E2) ph = PH_FLAT;
    else if (t < E3) ph = PH_FALL;
    else             ph = PH_NONE;
  end
endmodule

// File: rtl/xps_ctrl.sv
module xps_ctrl
  import xps_pkg::*;
#(
  parameter int N  = 10,
  parameter int TW = 16,
  parameter int RW = 4,
  parameter int EP = 100,
  parameter int RT = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          epoch_start,
  input  logic          init_start,
  input  logic [N-1:0]  fire_vec,
  input  logic [N-1:0]  row_en,
  input  logic [N-1:0]  col_en,
  output st_e           st,
  output logic [TW-1:0] t,
  output logic [RW-1:0] row,
  output logic [N-1:0]  fire_q,
  output logic [N-1:0]  row_en_q,
  output logic [N-1:0]  col_en_q,
  output logic          busy,
  output logic          done
);
  localparam logic [TW-1:0] EP_LAST  = TW'(EP - 1);
  localparam logic [TW-1:0] RT_LAST  = TW'(RT - 1);
  localparam logic [RW-1:0] ROW_LAST = RW'(N - 1);

  logic init_done;
  logic ep_end, init_end;

  assign ep_end   = (st == ST_EPOCH) && (t == EP_LAST);
  assign init_end = (st == ST_INIT) && (t == RT_LAST) && (row == ROW_LAST);
  assign busy     = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      t         <= '0;
      row       <= '0;
      fire_q    <= '0;
      row_en_q  <= '0;
      col_en_q  <= '0;
      init_done <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= ep_end || init_end;
      case (st)
        ST_IDLE: begin
          if (init_start) begin
            st       <= ST_INIT;
            t        <= '0;
            row      <= '0;
            row_en_q <= row_en;
            col_en_q <= col_en;
          end else if (epoch_start && init_done) begin
            st       <= ST_EPOCH;
            t        <= '0;
            fire_q   <= fire_vec;
            row_en_q <= row_en;
            col_en_q <= col_en;
          end
        end
        ST_EPOCH: begin
          if (t == EP_LAST) st <= ST_IDLE;
          else              t  <= t + 1'b1;
        end
        ST_INIT: begin
          if (t == RT_LAST) begin
            t <= '0;
            if (row == ROW_LAST) begin
              st        <= ST_IDLE;
              init_done <= 1'b1;
            end else begin
              row <= row + 1'b1;
            end
          end else begin
            t <= t + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9: the end-of-window flag never lasts two cycles
  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done held longer than one cycle");

  // R4: no epoch runs before initialisation has finished
  p_epoch_after_init_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_EPOCH) |-> init_done) else $error("epoch before init");

  // R10: an epoch in progress steps one cycle at a time whatever arrives
  p_epoch_step_r10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_EPOCH && t != EP_LAST) |=> (st == ST_EPOCH && t == $past(t) + 1'b1))
    else $error("epoch counter disturbed");

  // R3: rows advance in ascending order at the end of each slot
  p_row_step_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_INIT && t == RT_LAST && row != ROW_LAST) |=> (row == $past(row) + 1'b1))
    else $error("row order broken");
endmodule

// File: rtl/xps_line.sv
module xps_line
  import xps_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  st_e        st,
  input  logic       fire,
  input  logic       ren,
  input  logic       cen,
  input  logic       row_hit,
  input  phase_e     prog_ph,
  input  phase_e     read_ph,
  input  phase_e     rst_ph,
  output logic       wl,
  output logic [1:0] mode,
  output logic [1:0] ph
);
  logic   wl_n;
  mode_e  md_n;
  phase_e ph_n;

  always_comb begin
    wl_n = 1'b0;
    md_n = MD_IDLE;
    ph_n = PH_NONE;
    case (st)
      ST_EPOCH: begin
        if (fire) begin
          if (prog_ph != PH_NONE) begin
            wl_n = ren;
            if (cen) begin
              md_n = MD_SET;
              ph_n = prog_ph;
            end
          end
        end else if (read_ph != PH_NONE && cen) begin
          md_n = MD_READ;
          ph_n = read_ph;
        end
      end
      ST_INIT: begin
        if (rst_ph != PH_NONE) begin
          wl_n = ren & row_hit;
          if (cen) begin
            md_n = MD_RESET;
            ph_n = rst_ph;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wl   <= 1'b0;
      mode <= 2'b00;
      ph   <= 2'b00;
    end else begin
      wl   <= wl_n;
      mode <= md_n;
      ph   <= ph_n;
    end
  end

  // R3: during initialisation only the selected row may gate
  p_wl_needs_hit_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_INIT && !row_hit) |=> !wl) else $error("unselected row gated");

  // R6: a silent neuron never gates its wordline in an epoch
  p_nofire_no_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_EPOCH && !fire) |=> !wl) else $error("silent neuron gated");

  // R7: a disabled column stays idle
  p_col_off_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !cen |=> (mode == 2'b00 && ph == 2'b00)) else $error("disabled column driven");
endmodule

// File: rtl/xps_pulse_seq.sv
module xps_pulse_seq
  import xps_pkg::*;
#(
  parameter int N           = 10,
  parameter int CLK_PS      = 5000,
  parameter int SET_RISE_NS = 50,
  parameter int SET_FLAT_NS = 300,
  parameter int SET_FALL_NS = 1000,
  parameter int RST_RISE_NS = 20,
  parameter int RST_FLAT_NS = 50,
  parameter int RST_FALL_NS = 5,
  parameter int RD_RISE_NS  = 10,
  parameter int RD_FLAT_NS  = 100,
  parameter int RD_FALL_NS  = 10,
  parameter int EPOCH_NS    = 100000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           epoch_start,
  input  logic           init_start,
  input  logic [N-1:0]   fire_vec,
  input  logic [N-1:0]   row_en,
  input  logic [N-1:0]   col_en,
  output logic [N-1:0]   wl_gate,
  output logic [2*N-1:0] bl_mode,
  output logic [2*N-1:0] bl_phase,
  output logic           busy,
  output logic           done
);
  localparam int SR = ns2cyc(SET_RISE_NS, CLK_PS);
  localparam int SF = ns2cyc(SET_FLAT_NS, CLK_PS);
  localparam int SL = ns2cyc(SET_FALL_NS, CLK_PS);
  localparam int XR = ns2cyc(RST_RISE_NS, CLK_PS);
  localparam int XF = ns2cyc(RST_FLAT_NS, CLK_PS);
  localparam int XL = ns2cyc(RST_FALL_NS, CLK_PS);
  localparam int RR = ns2cyc(RD_RISE_NS, CLK_PS);
  localparam int RF = ns2cyc(RD_FLAT_NS, CLK_PS);
  localparam int RL = ns2cyc(RD_FALL_NS, CLK_PS);
  localparam int EP = ns2cyc(EPOCH_NS, CLK_PS);
  localparam int RT = XR + XF + XL;
  localparam int MAXC = imax(imax(EP, RT), imax(SR + SF + SL, RR + RF + RL));
  localparam int TW = $clog2(MAXC + 1);
  localparam int RW = (N > 1) ? $clog2(N) : 1;

  st_e           st;
  logic [TW-1:0] t;
  logic [RW-1:0] row;
  logic [N-1:0]  fire_q, row_en_q, col_en_q;
  phase_e        prog_ph, read_ph, rst_ph;

  xps_ctrl #(.N(N), .TW(TW), .RW(RW), .EP(EP), .RT(RT)) u_ctrl (
    .clk(clk), .rst(rst), .epoch_start(epoch_start), .init_start(init_start),
    .fire_vec(fire_vec), .row_en(row_en), .col_en(col_en),
    .st(st), .t(t), .row(row), .fire_q(fire_q), .row_en_q(row_en_q),
    .col_en_q(col_en_q), .busy(busy), .done(done)
  );

  xps_phase_timer #(.TW(TW), .RISE(SR), .FLAT(SF), .FALL(SL)) u_prog (.t(t), .ph(prog_ph));
  xps_phase_timer #(.TW(TW), .RISE(RR), .FLAT(RF), .FALL(RL)) u_read (.t(t), .ph(read_ph));
  xps_phase_timer #(.TW(TW), .RISE(XR), .FLAT(XF), .FALL(XL)) u_rset (.t(t), .ph(rst_ph));

  for (genvar i = 0; i < N; i++) begin : g_line
    logic hit;
    assign hit = (row == RW'(i));
    xps_line u_line (
      .clk(clk), .rst(rst), .st(st),
      .fire(fire_q[i]), .ren(row_en_q[i]), .cen(col_en_q[i]), .row_hit(hit),
      .prog_ph(prog_ph), .read_ph(read_ph), .rst_ph(rst_ph),
      .wl(wl_gate[i]), .mode(bl_mode[2*i +: 2]), .ph(bl_phase[2*i +: 2])
    );
  end

  // R3: at most one wordline is gated while rows are being reset
  p_init_rows_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_INIT) |=> $onehot0(wl_gate)) else $error("several rows gated in init");
endmodule

// File: tb/sim_xps_pulse_seq.sv
`timescale 1ns/1ps
module sim_xps_pulse_seq;
  localparam int N = 10;
  localparam int CLK_PS = 5000;
  localparam int EPOCH_NS = 2000;
  localparam int LIMIT = 150000;

  function automatic int cyc(input int ns);
    int c;
    c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int SR = cyc(50), SF = cyc(300), SL = cyc(1000);
  localparam int XR = cyc(20), XF = cyc(50), XL = cyc(5);
  localparam int RR = cyc(10), RF = cyc(100), RL = cyc(10);
  localparam int EP = cyc(EPOCH_NS);
  localparam int RT = XR + XF + XL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic epoch_start = 1'b0, init_start = 1'b0;
  logic [N-1:0] fire_vec = '0, row_en = '1, col_en = '1;
  logic [N-1:0] wl_gate;
  logic [2*N-1:0] bl_mode, bl_phase;
  logic busy, done;

  always #2.5 clk = ~clk;

  xps_pulse_seq #(.N(N), .CLK_PS(CLK_PS), .EPOCH_NS(EPOCH_NS)) u0 (
    .clk(clk), .rst(rst), .epoch_start(epoch_start), .init_start(init_start),
    .fire_vec(fire_vec), .row_en(row_en), .col_en(col_en),
    .wl_gate(wl_gate), .bl_mode(bl_mode), .bl_phase(bl_phase),
    .busy(busy), .done(done)
  );

  // ---------------- behavioural reference model ----------------
  function automatic int ph_of(input int k, input int r, input int f, input int l);
    if (k < r) return 1;
    if (k < r + f) return 2;
    if (k < r + f + l) return 3;
    return 0;
  endfunction

  int m_kind = 0;  // 0 idle, 1 epoch, 2 init
  int m_e = 0;
  logic m_init = 1'b0;
  logic [N-1:0] m_fire = '0, m_ren = '0, m_cen = '0;
  logic [N-1:0] x_wl = '0;
  logic [2*N-1:0] x_mode = '0, x_ph = '0;
  logic x_busy = 1'b0, x_done = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_kind = 0; m_e = 0; m_init = 1'b0;
      x_wl = '0; x_mode = '0; x_ph = '0; x_busy = 1'b0; x_done = 1'b0;
    end else begin
      x_done = 1'b0;
      x_wl = '0; x_mode = '0; x_ph = '0;
      if (m_kind != 0) begin
        int k;
        m_e = m_e + 1;
        k = m_e - 1;
        if (m_kind == 1) begin
          for (int i = 0; i < N; i++) begin
            int p;
            if (m_fire[i]) begin
              p = ph_of(k, SR, SF, SL);
              if (p != 0) begin
                x_wl[i] = m_ren[i];
                if (m_cen[i]) begin x_mode[2*i +: 2] = 2'd2; x_ph[2*i +: 2] = 2'(p); end
              end
            end else begin
              p = ph_of(k, RR, RF, RL);
              if (p != 0 && m_cen[i]) begin x_mode[2*i +: 2] = 2'd1; x_ph[2*i +: 2] = 2'(p); end
            end
          end
          if (m_e == EP) begin x_done = 1'b1; m_kind = 0; end
        end else begin
          int r, tt, p;
          r = k / RT; tt = k % RT;
          p = ph_of(tt, XR, XF, XL);
          if (p != 0) begin
            x_wl[r] = m_ren[r];
            for (int i = 0; i < N; i++)
              if (m_cen[i]) begin x_mode[2*i +: 2] = 2'd3; x_ph[2*i +: 2] = 2'(p); end
          end
          if (m_e == N * RT) begin x_done = 1'b1; m_kind = 0; m_init = 1'b1; end
        end
      end else begin
        if (init_start) begin
          m_kind = 2; m_e = 0; m_ren = row_en; m_cen = col_en;
        end else if (epoch_start && m_init) begin
          m_kind = 1; m_e = 0; m_fire = fire_vec; m_ren = row_en; m_cen = col_en;
        end
      end
      x_busy = (m_kind != 0);
    end
  end

  // ---------------- checking, all in one process ----------------
  int checks = 0, fails = 0, cycles = 0;
  int wl0_c = 0, wl3_c = 0, wl4_c = 0, ph7_c = 0, flat0_c = 0, rd4_c = 0, flat9_c = 0, done_c = 0;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cycles++;
    if (cycles > LIMIT) begin
      fails++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", cycles, LIMIT);
      summary();
    end
    if (!rst) begin
      string tag;
      tag = (m_kind == 2 || x_mode[1:0] == 2'd3) ? "R3" : "R5/R6";
      // per-cycle compare against the model (R2, R3, R5, R6, R7, R8, R9, R10)
      chk(wl_gate == x_wl, {tag, " wl_gate"}, int'(wl_gate), int'(x_wl));
      chk(bl_mode == x_mode, {tag, " bl_mode"}, int'(bl_mode), int'(x_mode));
      chk(bl_phase == x_ph, "R2 bl_phase", int'(bl_phase), int'(x_ph));
      chk(done == x_done, "R9 done", int'(done), int'(x_done));
      chk(busy == x_busy, "R10 busy", int'(busy), int'(x_busy));
      wl0_c   += int'(wl_gate[0]);
      wl3_c   += int'(wl_gate[3]);
      wl4_c   += int'(wl_gate[4]);
      ph7_c   += int'(bl_phase[15:14] != 2'b00);
      flat0_c += int'(bl_phase[1:0] == 2'b10);
      rd4_c   += int'(bl_phase[9:8] == 2'b10 && bl_mode[9:8] == 2'b01);
      flat9_c += int'(bl_phase[19:18] == 2'b10 && bl_mode[19:18] == 2'b10);
      done_c  += int'(done);
    end
  endtask

  task automatic cmd(input bit do_init, input bit do_epoch);
    init_start = do_init; epoch_start = do_epoch;
    tick();
    init_start = 1'b0; epoch_start = 1'b0;
  endtask

  task automatic wait_done();
    int guard;
    guard = 0;
    do begin tick(); guard++; end while (!done && guard < 4 * N * RT + 2 * EP);
  endtask

  initial begin
    int s_wl0, s_wl3, s_wl4, s_ph7, s_f0, s_rd4, s_f9, s_dn;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1: outputs idle after reset
    chk(wl_gate == '0 && bl_mode == '0 && bl_phase == '0 && !busy && !done,
        "R1 reset state", int'(busy), 0);

    // R4: epoch before any initialisation is ignored
    fire_vec = '1;
    cmd(1'b0, 1'b1);
    repeat (5) tick();
    chk(!busy && wl_gate == '0, "R4 epoch before init", int'(busy), 0);

    // R3/R7/R10: initialisation with row 3 and column 7 disabled, epoch request while busy
    row_en = ~(N'(1) << 3); col_en = ~(N'(1) << 7);
    s_wl0 = wl0_c; s_wl3 = wl3_c; s_ph7 = ph7_c; s_dn = done_c;
    cmd(1'b1, 1'b0);
    repeat (20) tick();
    cmd(1'b0, 1'b1);
    row_en = '1; col_en = '1;   // R8: ignored until the next command
    wait_done();
    tick();
    chk(wl0_c - s_wl0 == RT, "R3 row0 gate cycles", wl0_c - s_wl0, RT);
    chk(wl3_c - s_wl3 == 0, "R7 disabled row", wl3_c - s_wl3, 0);
    chk(ph7_c - s_ph7 == 0, "R7 disabled column", ph7_c - s_ph7, 0);
    chk(done_c - s_dn == 1, "R9 one done per command", done_c - s_dn, 1);
    chk(!busy, "R10 epoch during init dropped", int'(busy), 0);

    // R5/R6/R8: epoch with pattern neurons 0,1,2,3,5; vector changes mid-epoch
    fire_vec = 10'b0000101111;
    s_wl4 = wl4_c; s_f0 = flat0_c; s_rd4 = rd4_c; s_dn = done_c;
    cmd(1'b0, 1'b1);
    repeat (50) tick();
    fire_vec = '1;
    wait_done();
    tick();
    chk(wl4_c - s_wl4 == 0, "R8 mid-epoch fire change", wl4_c - s_wl4, 0);
    chk(flat0_c - s_f0 == SF, "R2 R5 set flat length", flat0_c - s_f0, SF);
    chk(rd4_c - s_rd4 == RF, "R6 read flat length", rd4_c - s_rd4, RF);
    chk(done_c - s_dn == 1, "R9 epoch done", done_c - s_dn, 1);

    // R10: both commands in one idle cycle, initialisation wins
    cmd(1'b1, 1'b1);
    tick();
    chk(bl_mode[1:0] == 2'b11, "R10 init priority", int'(bl_mode[1:0]), 3);
    wait_done();

    // R11: back-to-back epochs with pattern neurons 4,6,7,8,9
    fire_vec = 10'b1111010000;
    s_f9 = flat9_c;
    cmd(1'b0, 1'b1);
    wait_done();
    cmd(1'b0, 1'b1);
    wait_done();
    tick();
    chk(flat9_c - s_f9 == 2 * SF, "R11 repeated programming", flat9_c - s_f9, 2 * SF);
    repeat (5) tick();
    summary();
  end
endmodule